// File: doc/BRIEF.md
# Serial Register Access Chain

This block is the shift-register front end that lets a serial test port reach a bank of internal 32-bit registers. A host shifts a 40-bit frame through the chain, least significant bit first. The frame holds a data word, a 7-bit register index and a direction flag. When the update strobe arrives, the block decodes the frame. A write frame sends the data to the addressed register. A read frame fetches the addressed register into a holding latch.

The capture strobe loads the holding latch into the data field of the chain. The host therefore receives the result of a read while it shifts in the next frame, so N reads take N+1 scans. Because of this, a read of a register whose read has a side effect should be followed by a closing scan that reads a harmless index, such as index 0. All strobes and the serial bits are sampled on the rising edge of `clk`. The register bank sits outside the block. It is reached through a generic port with one cycle of read latency.

Top module: `regscan_access`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `tdo`, `bank_we` and `bank_re` are 0. The holding latch is 0, so the first capture after reset returns zero data.
- R2: The frame is shifted LSB first. Bits [31:0] are data, bits [38:32] are the register index, and bit 39 is the direction flag.
- R3: In a cycle with `cap_en` high, the chain loads the holding latch into bits [31:0] and zero into bits [39:32]. `tdo` then presents bit 0, followed by one further bit per cycle with `shift_en` high. If `cap_en` and `shift_en` are both high, capture takes priority.
- R4: An update with flag 1 and an implemented index pulses `bank_we` for exactly one cycle, in the cycle after the update. `bank_addr` and `bank_wdata` carry the frame's index and data in that cycle. `bank_re` stays low.
- R5: An update with flag 0 and an implemented index pulses `bank_re` for exactly one cycle, in the cycle after the update, with `bank_addr` set to the index. `bank_rdata` is sampled one cycle later into the holding latch.
- R6: Each scan returns, in its data field, the value fetched by the most recent earlier read frame. A write frame leaves the holding latch unchanged.
- R7: An index at or above `NUM_REGS` (default 9) produces no bank strobe. A write to such an index is dropped. A read of such an index sets the holding latch to zero.
- R8: With `shift_en` high and no capture, the chain is a 40-stage delay from `tdi` to `tdo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the chain and the bank port |
| rst | input | 1 | Synchronous active-high reset |
| tdi | input | 1 | Serial data into the chain's top bit |
| tdo | output | 1 | Serial data out, bit 0 of the chain |
| cap_en | input | 1 | Capture strobe: load the read result into the chain |
| shift_en | input | 1 | Shift strobe: move the chain one bit toward `tdo` |
| upd_en | input | 1 | Update strobe: decode and act on the shifted frame |
| bank_addr | output | 7 | Register index presented to the bank |
| bank_wdata | output | 32 | Write data presented to the bank |
| bank_we | output | 1 | One-cycle write strobe |
| bank_re | output | 1 | One-cycle read strobe |
| bank_rdata | input | 32 | Bank read data, valid the cycle after `bank_re` |

## Verification
The main function is exercised with a sequence of full scans that mixes reads and writes. The sequence includes back-to-back reads, a read that directly follows a write to the same index, and reads and writes at the last implemented index, at the first unimplemented index and at the top index. A value returned one scan late separates correct one-frame pipelining from a design that returns data during the same scan or two scans late. A write followed by a read-back separates a frame decoded with the correct field positions from one with swapped fields. Reads at indices 8, 9 and 127 separate the range boundary from an off-by-one comparison. Counting the strobes in each scan shows whether out-of-range frames are suppressed, and a separate raw shift without capture confirms the 40-stage path.

// File: rtl/regscan_pkg.sv
package regscan_pkg;

  localparam int DEF_DATA_W   = 32;
  localparam int DEF_ADDR_W   = 7;
  localparam int DEF_NUM_REGS = 9;

  // Action decoded from a frame at update time
  typedef enum logic [1:0] {
    OP_NONE      = 2'd0,
    OP_WRITE     = 2'd1,
    OP_READ      = 2'd2,
    OP_NULL_READ = 2'd3
  } scan_op_e;

endpackage

// File: rtl/regscan_shifter.sv
module regscan_shifter #(
  parameter int DATA_W  = 32,
  parameter int FRAME_W = 40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cap_en,
  input  logic               shift_en,
  input  logic               tdi,
  input  logic [DATA_W-1:0]  cap_data,
  output logic [FRAME_W-1:0] frame_q,
  output logic               tdo
);

  localparam int HIGH_W = FRAME_W - DATA_W;

  logic [FRAME_W-1:0] chain_q;

  // Capture has priority over shift; the header bits capture as zero
  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else if (cap_en) begin
      chain_q <= {{HIGH_W{1'b0}}, cap_data};
    end else if (shift_en) begin
      chain_q <= {tdi, chain_q[FRAME_W-1:1]};
    end
  end

  assign frame_q = chain_q;
  assign tdo     = chain_q[0];

endmodule

// File: rtl/regscan_decode.sv
module regscan_decode
  import regscan_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 7,
  parameter int NUM_REGS = 9,
  parameter int FRAME_W  = DATA_W + ADDR_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               upd_en,
  input  logic [FRAME_W-1:0] frame,
  output logic [ADDR_W-1:0]  bank_addr,
  output logic [DATA_W-1:0]  bank_wdata,
  output logic               bank_we,
  output logic               bank_re,
  output scan_op_e           op_q
);

  localparam int FLAG_BIT = DATA_W + ADDR_W;

  logic [DATA_W-1:0] f_data;
  logic [ADDR_W-1:0] f_addr;
  logic              f_write;
  logic              in_range;
  scan_op_e          op_d;

  assign f_data  = frame[DATA_W-1:0];
  assign f_addr  = frame[DATA_W +: ADDR_W];
  assign f_write = frame[FLAG_BIT];

  // The range check disappears when every index is implemented
  generate
    if (NUM_REGS >= (1 << ADDR_W)) begin : g_full
      assign in_range = 1'b1;
    end else begin : g_part
      assign in_range = (32'(f_addr) < 32'(NUM_REGS));
    end
  endgenerate

  always_comb begin
    op_d = OP_NONE;
    if (upd_en) begin
      if (f_write) begin
        op_d = in_range ? OP_WRITE : OP_NONE;
      end else begin
        op_d = in_range ? OP_READ : OP_NULL_READ;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q       <= OP_NONE;
      bank_we    <= 1'b0;
      bank_re    <= 1'b0;
      bank_addr  <= '0;
      bank_wdata <= '0;
    end else begin
      op_q    <= op_d;
      bank_we <= (op_d == OP_WRITE);
      bank_re <= (op_d == OP_READ);
      if (upd_en) begin
        bank_addr <= f_addr;
      end
      if (op_d == OP_WRITE) begin
        bank_wdata <= f_data;
      end
    end
  end

endmodule

// File: rtl/regscan_holdreg.sv
module regscan_holdreg
  import regscan_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  scan_op_e          op,
  input  logic [DATA_W-1:0] bank_rdata,
  output logic [DATA_W-1:0] held_q
);

  logic rd_wait_q;

  // Bank data arrives one cycle after the read strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_wait_q <= 1'b0;
      held_q    <= '0;
    end else begin
      rd_wait_q <= (op == OP_READ);
      if (rd_wait_q) begin
        held_q <= bank_rdata;
      end else if (op == OP_NULL_READ) begin
        held_q <= '0;
      end
    end
  end

endmodule

// File: rtl/regscan_access.sv
module regscan_access
  import regscan_pkg::*;
#(
  parameter int DATA_W   = DEF_DATA_W,
  parameter int ADDR_W   = DEF_ADDR_W,
  parameter int NUM_REGS = DEF_NUM_REGS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tdi,
  output logic              tdo,
  input  logic              cap_en,
  input  logic              shift_en,
  input  logic              upd_en,
  output logic [ADDR_W-1:0] bank_addr,
  output logic [DATA_W-1:0] bank_wdata,
  output logic              bank_we,
  output logic              bank_re,
  input  logic [DATA_W-1:0] bank_rdata
);

  localparam int FRAME_W = DATA_W + ADDR_W + 1;

  logic [FRAME_W-1:0] frame_q;
  logic [DATA_W-1:0]  held_q;
  scan_op_e           op_q;

  regscan_shifter #(
    .DATA_W (DATA_W),
    .FRAME_W(FRAME_W)
  ) u_shift (
    .clk     (clk),
    .rst     (rst),
    .cap_en  (cap_en),
    .shift_en(shift_en),
    .tdi     (tdi),
    .cap_data(held_q),
    .frame_q (frame_q),
    .tdo     (tdo)
  );

  regscan_decode #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .NUM_REGS(NUM_REGS),
    .FRAME_W (FRAME_W)
  ) u_dec (
    .clk       (clk),
    .rst       (rst),
    .upd_en    (upd_en),
    .frame     (frame_q),
    .bank_addr (bank_addr),
    .bank_wdata(bank_wdata),
    .bank_we   (bank_we),
    .bank_re   (bank_re),
    .op_q      (op_q)
  );

  regscan_holdreg #(
    .DATA_W(DATA_W)
  ) u_hold (
    .clk       (clk),
    .rst       (rst),
    .op        (op_q),
    .bank_rdata(bank_rdata),
    .held_q    (held_q)
  );

endmodule

// File: rtl/regscan_access_chk.sv
module regscan_access_chk #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 7,
  parameter int NUM_REGS = 9,
  parameter int FRAME_W  = DATA_W + ADDR_W + 1
) (
  input logic               clk,
  input logic               rst,
  input logic               cap_en,
  input logic               upd_en,
  input logic               bank_we,
  input logic               bank_re,
  input logic               tdo,
  input logic [ADDR_W-1:0]  bank_addr,
  input logic [FRAME_W-1:0] frame_q
);

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!bank_we && !bank_re && !tdo)); // R1
  AST_CAPTURE_HEADER: assert property (@(posedge clk) disable iff (rst)
    cap_en |=> (frame_q[FRAME_W-1:DATA_W] == '0)); // R3
  AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) bank_we |=> !bank_we); // R4
  AST_WE_AFTER_UPDATE: assert property (@(posedge clk) disable iff (rst) bank_we |-> $past(upd_en)); // R4
  AST_RE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) bank_re |=> !bank_re); // R5
  AST_RE_AFTER_UPDATE: assert property (@(posedge clk) disable iff (rst) bank_re |-> $past(upd_en)); // R5
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst) $onehot0({bank_we, bank_re})); // R4
  AST_STROBE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (bank_we || bank_re) |-> (32'(bank_addr) < 32'(NUM_REGS))); // R7

endmodule

bind regscan_access regscan_access_chk #(
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W),
  .NUM_REGS(NUM_REGS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cap_en   (cap_en),
  .upd_en   (upd_en),
  .bank_we  (bank_we),
  .bank_re  (bank_re),
  .tdo      (tdo),
  .bank_addr(bank_addr),
  .frame_q  (frame_q)
);

// File: tb/regscan_access_test.sv
`timescale 1ns/1ps
module regscan_access_test;

  localparam int NREG = 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tdi = 1'b0;
  logic        cap_en = 1'b0;
  logic        shift_en = 1'b0;
  logic        upd_en = 1'b0;
  logic        tdo;
  logic [6:0]  bank_addr;
  logic [31:0] bank_wdata;
  logic        bank_we;
  logic        bank_re;
  logic [31:0] bank_rdata = '0;

  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  regscan_access uut (
    .clk       (clk),
    .rst       (rst),
    .tdi       (tdi),
    .tdo       (tdo),
    .cap_en    (cap_en),
    .shift_en  (shift_en),
    .upd_en    (upd_en),
    .bank_addr (bank_addr),
    .bank_wdata(bank_wdata),
    .bank_we   (bank_we),
    .bank_re   (bank_re),
    .bank_rdata(bank_rdata)
  );

  // Register bank model: synchronous read, one cycle of latency
  logic [31:0] mem [0:127];
  int          we_total = 0;
  int          re_total = 0;
  logic [6:0]  last_waddr = '0;
  logic [31:0] last_wdata = '0;

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 32'hC0DE0000 | 32'(i);
  end

  always @(posedge clk) begin
    if (bank_we) begin
      mem[bank_addr] <= bank_wdata;
      we_total       <= we_total + 1;
      last_waddr     <= bank_addr;
      last_wdata     <= bank_wdata;
    end
    if (bank_re) begin
      bank_rdata <= mem[bank_addr];
      re_total   <= re_total + 1;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One full scan: capture, 40 shifts, update, idle
  task automatic scan(input logic wr, input logic [6:0] a, input logic [31:0] d,
                      output logic [39:0] got);
    logic [39:0] frame;
    frame = {wr, a, d};   // R2 flag bit 39, index [38:32], data [31:0]
    @(negedge clk) cap_en = 1'b1;
    @(negedge clk) cap_en = 1'b0;
    shift_en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      tdi    = frame[i];
      got[i] = tdo;
      @(negedge clk);
    end
    shift_en = 1'b0;
    upd_en   = 1'b1;
    @(negedge clk) upd_en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // {flag, index, data, expected data returned by this scan}
  localparam logic [71:0] VEC [14] = '{
    {1'b0, 7'd3,   32'h0,        32'h00000000},
    {1'b0, 7'd5,   32'h0,        32'hC0DE0003},
    {1'b1, 7'd2,   32'h12345678, 32'hC0DE0005},
    {1'b0, 7'd2,   32'h0,        32'hC0DE0005},
    {1'b0, 7'd0,   32'h0,        32'h12345678},
    {1'b1, 7'd100, 32'hDEADBEEF, 32'hC0DE0000},
    {1'b0, 7'd100, 32'h0,        32'hC0DE0000},
    {1'b0, 7'd8,   32'h0,        32'h00000000},
    {1'b1, 7'd8,   32'hA5A5F00F, 32'hC0DE0008},
    {1'b0, 7'd8,   32'h0,        32'hC0DE0008},
    {1'b0, 7'd127, 32'h0,        32'hA5A5F00F},
    {1'b0, 7'd0,   32'h0,        32'h00000000},
    {1'b0, 7'd9,   32'h0,        32'hC0DE0000},
    {1'b0, 7'd1,   32'h0,        32'h00000000}
  };

  initial begin
    #100000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [39:0] got;
    logic [39:0] pat;
    int we0;
    int re0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet under reset
    check("R1 tdo", 64'(tdo), 64'd0);
    check("R1 strobes", 64'({bank_we, bank_re}), 64'd0);
    @(negedge clk) rst = 1'b0;
    check("R1 strobes after reset", 64'({bank_we, bank_re}), 64'd0);

    foreach (VEC[k]) begin
      logic        wr;
      logic [6:0]  a;
      logic [31:0] d;
      logic [31:0] e;
      logic        inr;
      {wr, a, d, e} = VEC[k];
      inr = (32'(a) < NREG);
      we0 = we_total;
      re0 = re_total;
      scan(wr, a, d, got);
      // R6 pipelined read result, R7 null read yields zero
      check($sformatf("R6 scan %0d data", k), 64'(got[31:0]), 64'(e));
      check($sformatf("R3 scan %0d header zero", k), 64'(got[39:32]), 64'd0);
      // R4 / R5 / R7 strobe counts
      check($sformatf("R4 scan %0d write strobes", k), 64'(we_total - we0), 64'(wr && inr));
      check($sformatf("R5 scan %0d read strobes", k), 64'(re_total - re0), 64'(!wr && inr));
      if (wr && inr) begin
        check($sformatf("R4 scan %0d write index", k), 64'(last_waddr), 64'(a));
        check($sformatf("R4 scan %0d write data", k), 64'(last_wdata), 64'(d));
      end
    end

    // R8: raw 40-stage delay without capture or update
    pat = 40'hA3_5C0F_F00D;
    shift_en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      tdi = pat[i];
      @(negedge clk);
    end
    for (int i = 0; i < 40; i++) begin
      tdi    = 1'b0;
      got[i] = tdo;
      @(negedge clk);
    end
    shift_en = 1'b0;
    check("R8 delay line", 64'(got), 64'(pat));

    // R3: capture wins over shift; held value is C0DE0001 from last read of index 1
    cap_en = 1'b1;
    shift_en = 1'b1;
    @(negedge clk);
    cap_en = 1'b0;
    shift_en = 1'b0;
    check("R3 capture priority bit0", 64'(tdo), 64'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule